// File: doc/BRIEF.md
# Sprite Attribute DMA Engine with Sample-Fetch Arbitration

This block halts the processor and copies one 256-byte memory page into a fixed sprite data register. Each byte takes two bus cycles: a read from the source page, then a write of that byte to the register address. A trigger pulse starts the copy and carries the page number. The page number forms the high byte of the source address, and a low-byte counter starts at zero. Before the first read, the engine waits 1 or 2 halt cycles, chosen by the parity of the processor cycle at the trigger.

A single-byte sample fetch has priority over the sprite copy. Once started, its countdown holds the processor halted, reads one byte at a supplied address and returns that byte with a strobe. If the processor has not yet confirmed that it is frozen when the countdown reaches a check value, the fetch is pushed back by two cycles. The sprite copy pauses during the fetch cycle and for one realignment cycle after it, then resumes where it stopped.

The engine drives the processor ready line. It also decides in which cycles the interrupt line is sampled. When ready returns high, a hold flag is raised for one cycle, and the interrupt line is not sampled in that cycle.

Top module: `spr_dma_engine`

## Requirements
- R1: A trigger accepted while no sprite copy is running drives `cpu_rdy_o` low from the next cycle. A trigger that arrives while a copy is running is ignored and does not change the page or the progress of the copy.
- R2: If `cyc_odd_i` is 0 when the trigger is accepted, the first source read comes in the third cycle after the accepting edge. If `cyc_odd_i` is 1, it comes in the second cycle.
- R3: The copy makes 512 bus accesses that alternate, starting with a read. Read k uses address {page, k}. The following write puts the byte just read onto address 16'h2004. Only one access takes place per cycle.
- R4: `cpu_rdy_o` stays low through the last write. It returns high in the cycle after that write, provided no sample fetch is pending.
- R5: `irq_hold_o` is 1 in exactly the first cycle in which `cpu_rdy_o` is high again. `cpu_irq_o` does not take a new value of `irq_line_i` from that cycle.
- R6: A sample start accepted while no fetch is pending holds `cpu_rdy_o` low. The fetch reads the supplied address in the 4th cycle after the accepting edge. `smp_done_o` pulses one cycle later, with the byte on `smp_data_o`. A start that arrives while a fetch is pending is ignored.
- R7: If `cpu_frozen_i` is 0 in the cycle where the countdown equals 2, the fetch moves to the 6th cycle after the accepting edge. This extension happens at most once per fetch.
- R8: The sprite copy makes no access in the fetch cycle or the cycle after it. It then continues with the same source address and the same held byte.
- R9: `cpu_irq_o` captures `irq_line_i` in these cycles: cycles where ready is high and the hold flag is clear, the first halted cycle after a sprite trigger, and halted cycles where the sample countdown equals 3. It keeps its value in every other halted cycle.
- R10: In reset, `cpu_rdy_o` is 1, and `irq_hold_o`, `cpu_irq_o`, `mem_rd_o`, `mem_wr_o` and `smp_done_o` are 0.
- R11: `mem_rd_o` and `mem_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start a sprite copy |
| trig_page_i | input | 8 | Source page number |
| cyc_odd_i | input | 1 | Parity of the current processor cycle |
| cpu_frozen_i | input | 1 | Processor confirms it is halted |
| smp_start_i | input | 1 | Start a sample fetch |
| smp_addr_i | input | 16 | Sample fetch address |
| irq_line_i | input | 1 | Raw interrupt request |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the read |
| mem_addr_o | output | 16 | Bus address |
| mem_rd_o | output | 1 | Bus read strobe |
| mem_wr_o | output | 1 | Bus write strobe |
| mem_wdata_o | output | 8 | Bus write data |
| smp_data_o | output | 8 | Fetched sample byte |
| smp_done_o | output | 1 | One-cycle strobe: sample byte valid |
| cpu_rdy_o | output | 1 | Processor ready; low halts it |
| irq_hold_o | output | 1 | Interrupt sampling held off this cycle |
| cpu_irq_o | output | 1 | Interrupt level as sampled for the processor |

## Verification
Some properties are checked by assertions in every cycle:
- at most one bus access per cycle;
- ready is low whenever either transfer is active;
- a hold flag that lasts one cycle and comes with each rise of ready;
- sprite state frozen while stalled;
- no access in the first halted cycle;
- the done strobe follows each fetch;
- the countdown never stretches a second time.

The exact cycles of each access, the parity-dependent start, the addresses and data that resume after a fetch, the two-cycle extension and the sampling points of the interrupt line can be shown only by the bench's scenarios. A scoreboard predicts these against a model of memory.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_SRC_RD = 2'd1,
    OP_REG_WR = 2'd2
  } spr_op_e;

  localparam logic [15:0] SPR_REG_ADDR_DEF = 16'h2004;
endpackage

// File: rtl/spr_xfer.sv
module spr_xfer
  import spr_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_BYTES = 256,
  parameter logic [ADDR_W-1:0] REG_ADDR = SPR_REG_ADDR_DEF,
  localparam int LO_W = $clog2(XFER_BYTES),
  localparam int PAGE_W = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              cyc_odd_i,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              start_o,
  output logic              act_o,
  output logic              act_nxt_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int XFER_CYC = 2 * XFER_BYTES;
  localparam int IDX_W = $clog2(XFER_CYC);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(XFER_CYC - 1);

  logic              act_q;
  logic [1:0]        dead_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LO_W-1:0]   lo_q;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] hold_q;

  logic    step;
  logic    access;
  logic    last;
  spr_op_e op;

  always_comb begin
    step   = act_q && !stall_i;
    access = step && (dead_q == 2'd0);
    if (!access)       op = OP_IDLE;
    else if (idx_q[0]) op = OP_REG_WR;
    else               op = OP_SRC_RD;
    last      = access && (idx_q == IDX_LAST);
    start_o   = trig_i && !act_q;
    act_nxt_o = start_o || (act_q && !last);
  end

  assign act_o   = act_q;
  assign rd_o    = (op == OP_SRC_RD);
  assign wr_o    = (op == OP_REG_WR);
  assign addr_o  = (op == OP_REG_WR) ? REG_ADDR : {page_q, lo_q};
  assign wdata_o = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      dead_q <= 2'd0;
      idx_q  <= '0;
      lo_q   <= '0;
      page_q <= '0;
      hold_q <= '0;
    end else if (start_o) begin
      act_q  <= 1'b1;
      dead_q <= cyc_odd_i ? 2'd1 : 2'd2;
      idx_q  <= '0;
      lo_q   <= '0;
      page_q <= page_i;
    end else if (step) begin
      if (dead_q != 2'd0) begin
        dead_q <= dead_q - 2'd1;
      end else begin
        idx_q <= idx_q + 1'b1;
        if (op == OP_SRC_RD) begin
          hold_q <= rdata_i;
          lo_q   <= lo_q + 1'b1;
        end
        if (last) act_q <= 1'b0;
      end
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (act_q && stall_i) |=> ($stable(idx_q) && $stable(lo_q) && $stable(hold_q))); // R8
  AST_FIRST_CYCLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> (!rd_o && !wr_o)); // R2
endmodule

// File: rtl/smp_fetch.sv
module smp_fetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W = 4,
  parameter int LEN = 4,
  parameter int CHK = 2,
  parameter int EXT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              frozen_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              busy_nxt_o,
  output logic              fetch_o,
  output logic              cnt3_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] CHK_C = CNT_W'(CHK);
  localparam logic [CNT_W-1:0] EXT_M1 = CNT_W'(EXT - 1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] THREE_C = CNT_W'(3);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              ext_ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, extend;

  always_comb begin
    busy_o  = (cnt_q != '0);
    fetch_o = (cnt_q == ONE_C);
    cnt3_o  = (cnt_q == THREE_C);
    accept  = start_i && !busy_o;
    extend  = busy_o && (cnt_q == CHK_C) && !frozen_i && ext_ok_q;
    if (accept)      cnt_nxt = LEN_C;
    else if (extend) cnt_nxt = cnt_q + EXT_M1;
    else if (busy_o) cnt_nxt = cnt_q - ONE_C;
    else             cnt_nxt = '0;
    busy_nxt_o = (cnt_nxt != '0);
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
  assign data_o = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ext_ok_q <= 1'b0;
      addr_q   <= '0;
      done_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      done_q <= fetch_o;
      if (accept) begin
        addr_q   <= addr_i;
        ext_ok_q <= 1'b1;
      end else if (extend) begin
        ext_ok_q <= 1'b0;
      end
      if (fetch_o) data_q <= rdata_i;
    end
  end

  AST_SMP_DONE: assert property (@(posedge clk) disable iff (rst)
    fetch_o |=> done_o); // R6
  AST_SMP_EXT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !ext_ok_q) |=> (cnt_q == $past(cnt_q) - ONE_C)); // R7
endmodule

// File: rtl/rdy_irq_ctl.sv
module rdy_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic spr_start_i,
  input  logic act_nxt_i,
  input  logic cnt3_i,
  input  logic irq_line_i,
  output logic rdy_o,
  output logic hold_o,
  output logic irq_o
);
  logic rdy_q, hold_q, special_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b1;
      hold_q    <= 1'b0;
      special_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rdy_q  <= !act_nxt_i;
      hold_q <= !rdy_q && !act_nxt_i;
      if (rdy_q && !hold_q) begin
        irq_q <= irq_line_i;
      end else if (special_q || cnt3_i) begin
        irq_q     <= irq_line_i;
        special_q <= 1'b0;
      end
      if (spr_start_i) special_q <= 1'b1;
    end
  end

  assign rdy_o  = rdy_q;
  assign hold_o = hold_q;
  assign irq_o  = irq_q;

  AST_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> hold_q); // R5
  AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !hold_q); // R5
  AST_NO_SAMPLE_HALTED: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && !special_q && !cnt3_i) |=> $stable(irq_q)); // R9
endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
  import spr_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_BYTES = 256,
  parameter logic [ADDR_W-1:0] REG_ADDR = SPR_REG_ADDR_DEF,
  parameter int SMP_CNT_W = 4,
  parameter int SMP_LEN = 4,
  parameter int SMP_CHK = 2,
  parameter int SMP_EXT = 2,
  localparam int PAGE_W = ADDR_W - $clog2(XFER_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [PAGE_W-1:0] trig_page_i,
  input  logic              cyc_odd_i,
  input  logic              cpu_frozen_i,
  input  logic              smp_start_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic              irq_line_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_done_o,
  output logic              cpu_rdy_o,
  output logic              irq_hold_o,
  output logic              cpu_irq_o
);
  logic              spr_start, spr_act, spr_nxt, spr_rd, spr_wr;
  logic [ADDR_W-1:0] spr_addr, smp_addr;
  logic              smp_busy, smp_nxt, smp_fetch, smp_cnt3;
  logic              realign_q;
  logic              stall;

  assign stall = smp_fetch || realign_q;

  always_ff @(posedge clk) begin
    if (rst) realign_q <= 1'b0;
    else     realign_q <= smp_fetch;
  end

  spr_xfer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_BYTES(XFER_BYTES), .REG_ADDR(REG_ADDR)
  ) u_xfer (
    .clk(clk), .rst(rst), .trig_i(trig_i), .page_i(trig_page_i),
    .cyc_odd_i(cyc_odd_i), .stall_i(stall), .rdata_i(mem_rdata_i),
    .start_o(spr_start), .act_o(spr_act), .act_nxt_o(spr_nxt),
    .rd_o(spr_rd), .wr_o(spr_wr), .addr_o(spr_addr), .wdata_o(mem_wdata_o)
  );

  smp_fetch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(SMP_CNT_W),
    .LEN(SMP_LEN), .CHK(SMP_CHK), .EXT(SMP_EXT)
  ) u_smp (
    .clk(clk), .rst(rst), .start_i(smp_start_i), .addr_i(smp_addr_i),
    .frozen_i(cpu_frozen_i), .rdata_i(mem_rdata_i),
    .busy_o(smp_busy), .busy_nxt_o(smp_nxt), .fetch_o(smp_fetch),
    .cnt3_o(smp_cnt3), .addr_o(smp_addr), .done_o(smp_done_o), .data_o(smp_data_o)
  );

  rdy_irq_ctl u_ctl (
    .clk(clk), .rst(rst), .spr_start_i(spr_start), .act_nxt_i(spr_nxt || smp_nxt),
    .cnt3_i(smp_cnt3), .irq_line_i(irq_line_i),
    .rdy_o(cpu_rdy_o), .hold_o(irq_hold_o), .irq_o(cpu_irq_o)
  );

  assign mem_rd_o   = spr_rd || smp_fetch;
  assign mem_wr_o   = spr_wr;
  assign mem_addr_o = smp_fetch ? smp_addr : spr_addr;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({spr_rd, spr_wr, smp_fetch})); // R11
  AST_RDY_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    (spr_act || smp_busy) |-> !cpu_rdy_o); // R4
endmodule

// File: tb/spr_dma_engine_tb.sv
`timescale 1ns/1ps
module spr_dma_engine_tb;
  typedef struct {
    int          cyc;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } op_t;

  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, odd = 1'b0, frozen = 1'b1;
  logic smp_start = 1'b0, irq_line = 1'b0;
  logic [7:0]  page = 8'h00;
  logic [15:0] smp_addr = 16'h0000;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, smp_data;
  logic mem_rd, mem_wr, smp_done, cpu_rdy, irq_hold, cpu_irq;

  int checks = 0, errs = 0, cyc = 0;
  bit finished = 1'b0;
  op_t exp_q[$];
  op_t got;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  spr_dma_engine u_dut (
    .clk(clk), .rst(rst), .trig_i(trig), .trig_page_i(page), .cyc_odd_i(odd),
    .cpu_frozen_i(frozen), .smp_start_i(smp_start), .smp_addr_i(smp_addr),
    .irq_line_i(irq_line), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .smp_data_o(smp_data), .smp_done_o(smp_done), .cpu_rdy_o(cpu_rdy),
    .irq_hold_o(irq_hold), .cpu_irq_o(cpu_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_fetch(input int c, input logic [15:0] a);
    op_t e;
    e.cyc = c; e.wr = 1'b0; e.addr = a; e.data = 8'h00; e.req = "R6";
    exp_q.push_back(e);
  endtask

  // Builds the expected access schedule of one sprite copy (R2, R3, R8)
  task automatic plan_xfer(input int t0, input bit is_odd, input logic [7:0] pg,
                           input int tf, input logic [15:0] fa, output int te);
    int dead, n, c;
    bit resumed;
    logic [7:0] held;
    op_t e;
    dead = is_odd ? 1 : 2; n = 0; c = t0 + 1; held = 8'h00; resumed = 1'b0;
    while (n < 512) begin
      if (tf >= 0 && c == tf) begin
        push_fetch(c, fa);
      end else if (tf >= 0 && c == tf + 1) begin
        resumed = 1'b1;
      end else if (dead > 0) begin
        dead--;
      end else begin
        e.cyc = c;
        if (n % 2 == 0) begin
          e.wr = 1'b0; e.addr = {pg, 8'(n / 2)}; e.data = 8'h00;
          held = mem_fn(e.addr);
        end else begin
          e.wr = 1'b1; e.addr = 16'h2004; e.data = held;
        end
        if (n == 0) e.req = "R2";
        else if (resumed) e.req = "R8";
        else e.req = "R3";
        resumed = 1'b0;
        exp_q.push_back(e);
        n++;
      end
      c++;
    end
    te = c - 1;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_wr) chk("R11", 1, 0, "read and write together");
      if (mem_rd || mem_wr) begin
        if (exp_q.size() == 0) begin
          chk("R3", {mem_wr, mem_addr}, 64'hFFFF_FFFF, "unexpected access");
        end else begin
          got = exp_q.pop_front();
          chk(got.req, {16'(cyc), mem_wr, mem_addr, mem_wr ? mem_wdata : 8'h00},
              {16'(got.cyc), got.wr, got.addr, got.data}, "bus access");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int t0, ts, te;
    repeat (4) @(negedge clk);
    chk("R10", cpu_rdy, 1, "reset rdy");
    chk("R10", {irq_hold, cpu_irq, mem_rd, mem_wr, smp_done}, 0, "reset outputs");
    rst = 1'b0;

    // Scenario 1: even parity, page 03, stray trigger, irq sampling
    irq_line = 1'b1;
    t0 = cyc + 2; wait_to(t0);
    plan_xfer(t0, 1'b0, 8'h03, -1, 16'h0000, te);
    trig = 1'b1; page = 8'h03; odd = 1'b0;
    wait_to(t0 + 1); trig = 1'b0; irq_line = 1'b0;
    chk("R1", cpu_rdy, 0, "rdy low after trigger");
    chk("R9", cpu_irq, 1, "sampled while ready");
    wait_to(t0 + 2); chk("R9", cpu_irq, 0, "first halted cycle sample");
    wait_to(t0 + 3); irq_line = 1'b1;
    wait_to(t0 + 50); trig = 1'b1; page = 8'h77; odd = 1'b1;
    wait_to(t0 + 51); trig = 1'b0;
    wait_to(t0 + 100);
    chk("R9", cpu_irq, 0, "no sample while halted");
    chk("R1", cpu_rdy, 0, "stray trigger keeps halt");
    wait_to(te); chk("R4", cpu_rdy, 0, "rdy low at last write");
    wait_to(te + 1);
    chk("R4", cpu_rdy, 1, "rdy back after copy");
    chk("R5", irq_hold, 1, "hold on release");
    wait_to(te + 2);
    chk("R5", irq_hold, 0, "hold one cycle");
    chk("R5", cpu_irq, 0, "no sample in hold cycle");
    wait_to(te + 3); chk("R9", cpu_irq, 1, "sample resumes");

    // Scenario 2: odd parity, page FE, sample fetch interrupts the copy
    t0 = te + 6; wait_to(t0);
    ts = t0 + 40;
    plan_xfer(t0, 1'b1, 8'hFE, ts + 4, 16'h3C5A, te);
    trig = 1'b1; page = 8'hFE; odd = 1'b1;
    wait_to(t0 + 1); trig = 1'b0;
    wait_to(ts); smp_start = 1'b1; smp_addr = 16'h3C5A;
    wait_to(ts + 1); smp_start = 1'b0;
    wait_to(ts + 4); chk("R6", smp_done, 0, "done not early");
    wait_to(ts + 5);
    chk("R6", smp_done, 1, "done strobe");
    chk("R6", smp_data, mem_fn(16'h3C5A), "fetched byte");
    wait_to(te + 1); chk("R4", cpu_rdy, 1, "rdy after stalled copy");

    // Scenario 3: standalone fetch, processor not frozen -> extension
    ts = te + 6;
    wait_to(ts - 3); irq_line = 1'b0; frozen = 1'b0;
    wait_to(ts);
    push_fetch(ts + 6, 16'h81E7);
    smp_start = 1'b1; smp_addr = 16'h81E7;
    wait_to(ts + 1); smp_start = 1'b0; irq_line = 1'b1;
    chk("R6", cpu_rdy, 0, "rdy low for fetch");
    wait_to(ts + 2); chk("R9", cpu_irq, 0, "no sample at countdown 4");
    smp_start = 1'b1; smp_addr = 16'h1111;
    wait_to(ts + 3); smp_start = 1'b0;
    chk("R9", cpu_irq, 1, "sample at countdown 3");
    wait_to(ts + 5); chk("R7", smp_done, 0, "extended fetch not done");
    wait_to(ts + 6); chk("R7", cpu_rdy, 0, "still halted in extension");
    wait_to(ts + 7);
    chk("R7", smp_done, 1, "extended done");
    chk("R7", smp_data, mem_fn(16'h81E7), "extended byte");
    chk("R5", {cpu_rdy, irq_hold}, 2'b11, "release after fetch");

    // Scenario 4: standalone fetch, processor frozen -> no extension
    ts = cyc + 4; wait_to(ts); frozen = 1'b1;
    push_fetch(ts + 4, 16'h4002);
    smp_start = 1'b1; smp_addr = 16'h4002;
    wait_to(ts + 1); smp_start = 1'b0;
    wait_to(ts + 4); chk("R6", smp_done, 0, "done not early");
    wait_to(ts + 5);
    chk("R6", smp_done, 1, "done strobe");
    chk("R6", smp_data, mem_fn(16'h4002), "fetched byte");

    wait_to(cyc + 4);
    chk("R3", exp_q.size(), 0, "all expected accesses seen");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule